// File: doc/BRIEF.md
# Robbed-Bit Signalling Store

This block sits behind a T1 receive framer. It takes the received channel bytes, each tagged with its frame number inside the multiframe and its channel number (0 to 23). It picks the signalling bit out of the signalling frames and keeps one status nibble per channel. Signalling arrives only once every six frames, but the stored nibble is held, so any channel can be read in any frame. The value read is always the last multiframe sample that was accepted.

Two framing modes are supported. The 24-frame extended mode carries four signalling bits per channel. The 12-frame legacy mode carries two. While the framer reports loss of frame synchronisation the store is frozen, and the multiframe during which the loss happened is thrown away. An optional debounce filter accepts a new value only when two consecutive multiframes agree on it.

Top module: `rbs_store`

## Requirements
- R1: After reset every channel's stored nibble is 0000, and a read returns 0000.
- R2: In extended mode (`esfMode`=1), bit 0 of a channel's byte in frames 6, 12, 18 and 24 is that channel's A, B, C and D bit. The nibble is {A,B,C,D}, with A in bit 3. It is stored when the frame-24 byte of that channel is accepted.
- R3: In legacy mode (`esfMode`=0), bit 0 in frames 6 and 12 gives A and B, and the sample is stored when the frame-12 byte arrives. Nibble bits 1:0 (C, D) are stored as 00. Frame numbers above 12 are ignored.
- R4: Bytes outside the last signalling frame never change a stored nibble. A partly received multiframe leaves every channel's stored value as it was.
- R5: `rdSig` returns the nibble of `rdChan` one cycle after `rdChan` is sampled. A read in the same cycle as a commit to that channel returns the previous value, and the following read returns the new one.
- R6: While `syncOk` is 0, received bytes have no effect on any stored nibble.
- R7: A multiframe during which `syncOk` dropped, or during which the mode changed, is not committed. Committing resumes with the next multiframe whose frame-1, channel-0 byte is received in sync.
- R8: With `debounceEn`=1, a channel's stored nibble changes only when the new multiframe sample equals the previous sample for that channel. A single differing sample is not stored.
- R9: With `debounceEn`=0, every committed sample replaces the stored nibble directly.
- R10: Each channel is independent. Bytes with `chanNum` of 24 or more are ignored, and reading a `rdChan` of 24 or more returns 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A received channel byte is present this cycle |
| rxByte | input | 8 | Received channel byte; bit 0 carries signalling |
| frameNum | input | 5 | Frame number within the multiframe, starting at 1 |
| chanNum | input | 5 | Channel number of the byte, 0 to 23 |
| syncOk | input | 1 | Frame synchronisation is held |
| esfMode | input | 1 | 1 = 24-frame four-bit mode, 0 = 12-frame two-bit mode |
| debounceEn | input | 1 | Enable two-sample debounce |
| rdChan | input | 5 | Channel to read |
| rdSig | output | 4 | Stored {A,B,C,D} of the channel read, one cycle later |

## Verification
Commit and read can fall in the same cycle. The last signalling byte of a channel can arrive in the very cycle that channel is read. The bench provokes this by steering `rdChan` to that channel exactly when its frame-24 byte is driven, and again on the next cycle. It expects the old nibble first and the freshly committed nibble one cycle later. Sync loss in the middle of a multiframe is also combined with continued byte traffic. That checks that the later, in-sync part of the same multiframe still commits nothing.

// File: rtl/rbs_pkg.sv
`timescale 1ns/1ps
package rbs_pkg;
  localparam int CHAN_IDX_W = 5;
  localparam int STAGE_W    = 3;
  localparam int NIB_W      = 4;

  typedef struct packed {
    logic [STAGE_W-1:0]    stage;    // [2]=A, [1]=B, [0]=C capture strobes
    logic                  commit;   // last signalling byte of a clean multiframe
    logic                  bitVal;   // signalling bit of this byte
    logic                  keepCD;   // four-bit mode
    logic                  debounce; // two-sample filter active
    logic [CHAN_IDX_W-1:0] chan;
  } rbsStrobe_t;
endpackage

// File: rtl/rbs_ctrl.sv
`timescale 1ns/1ps
module rbs_ctrl
  import rbs_pkg::*;
#(
  parameter int NUM_CHAN = 24,
  parameter int FRAME_W  = 5,
  parameter int SIG_STEP = 6,
  parameter int ESF_LEN  = 24,
  parameter int D4_LEN   = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  byteValid,
  input  logic [7:0]            rxByte,
  input  logic [FRAME_W-1:0]    frameNum,
  input  logic [CHAN_IDX_W-1:0] chanNum,
  input  logic                  syncOk,
  input  logic                  esfMode,
  input  logic                  debounceEn,
  output rbsStrobe_t            strb
);
  localparam logic [FRAME_W-1:0] ESF_LAST = FRAME_W'(ESF_LEN);
  localparam logic [FRAME_W-1:0] D4_LAST  = FRAME_W'(D4_LEN);
  localparam logic [FRAME_W-1:0] FIRST_FR = FRAME_W'(1);

  logic                mfClean;
  logic                esfQ;
  logic                accept;
  logic [FRAME_W-1:0]  mfLen;

  // Multiframe validity: lost on sync drop or mode change, regained at frame 1 / channel 0.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mfClean <= 1'b0;
      esfQ    <= 1'b0;
    end else begin
      esfQ <= esfMode;
      if (!syncOk || (esfMode != esfQ))
        mfClean <= 1'b0;
      else if (byteValid && frameNum == FIRST_FR && chanNum == '0)
        mfClean <= 1'b1;
    end
  end

  always_comb begin
    mfLen  = esfMode ? ESF_LAST : D4_LAST;
    accept = byteValid && syncOk && (chanNum < CHAN_IDX_W'(NUM_CHAN));
    strb          = '0;
    strb.chan     = chanNum;
    strb.bitVal   = rxByte[0];
    strb.keepCD   = esfMode;
    strb.debounce = debounceEn;
    if (accept) begin
      for (int s = 1; s <= STAGE_W; s++) begin
        if (frameNum == FRAME_W'(s * SIG_STEP) && frameNum < mfLen)
          strb.stage[STAGE_W - s] = 1'b1;
      end
      if (frameNum == mfLen && mfClean)
        strb.commit = 1'b1;
    end
  end

  // R7: a cycle without sync leaves no clean multiframe to commit next cycle
  p_no_commit_after_loss_r7: assert property (@(posedge clk) disable iff (!rstN)
    !syncOk |=> !strb.commit);

  // R10: out-of-range channel bytes produce no capture or commit
  p_chan_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && chanNum >= CHAN_IDX_W'(NUM_CHAN)) |-> (strb.stage == '0 && !strb.commit));
endmodule

// File: rtl/rbs_datapath.sv
`timescale 1ns/1ps
module rbs_datapath
  import rbs_pkg::*;
#(
  parameter int NUM_CHAN = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rbsStrobe_t            strb,
  input  logic [CHAN_IDX_W-1:0] rdChan,
  output logic [NIB_W-1:0]      rdSig
);
  logic [NUM_CHAN-1:0][STAGE_W-1:0] stgQ;
  logic [NUM_CHAN-1:0][NIB_W-1:0]   candQ;
  logic [NUM_CHAN-1:0][NIB_W-1:0]   storeQ;
  logic [STAGE_W-1:0]               stgSel;
  logic [NIB_W-1:0]                 sampleNib;

  always_comb begin
    stgSel    = stgQ[strb.chan];
    sampleNib = strb.keepCD ? {stgSel, strb.bitVal}
                            : {stgSel[STAGE_W-1], strb.bitVal, 2'b00};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stgQ   <= '0;
      candQ  <= '0;
      storeQ <= '0;
      rdSig  <= '0;
    end else begin
      for (int g = 0; g < NUM_CHAN; g++) begin
        if (strb.chan == CHAN_IDX_W'(g)) begin
          for (int k = 0; k < STAGE_W; k++)
            if (strb.stage[k]) stgQ[g][k] <= strb.bitVal;
          if (strb.commit) begin
            candQ[g] <= sampleNib;
            if (!strb.debounce || sampleNib == candQ[g])
              storeQ[g] <= sampleNib;
          end
        end
      end
      rdSig <= (rdChan < CHAN_IDX_W'(NUM_CHAN)) ? storeQ[rdChan] : '0;
    end
  end

  // R4: without a commit strobe nothing stored moves
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(storeQ));

  // R9: unfiltered commit lands the sample directly
  p_direct_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !strb.debounce) |=> storeQ[$past(strb.chan)] == $past(sampleNib));

  // R8: a sample disagreeing with the previous one never reaches the store
  p_debounce_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.debounce && sampleNib != candQ[strb.chan]) |=> $stable(storeQ));

  // R3: two-bit mode leaves C and D at zero on a direct commit
  p_cd_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !strb.keepCD && !strb.debounce) |=> storeQ[$past(strb.chan)][1:0] == 2'b00);
endmodule

// File: rtl/rbs_store.sv
`timescale 1ns/1ps
module rbs_store
  import rbs_pkg::*;
#(
  parameter int NUM_CHAN = 24,
  parameter int FRAME_W  = 5,
  parameter int SIG_STEP = 6,
  parameter int ESF_LEN  = 24,
  parameter int D4_LEN   = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  byteValid,
  input  logic [7:0]            rxByte,
  input  logic [FRAME_W-1:0]    frameNum,
  input  logic [CHAN_IDX_W-1:0] chanNum,
  input  logic                  syncOk,
  input  logic                  esfMode,
  input  logic                  debounceEn,
  input  logic [CHAN_IDX_W-1:0] rdChan,
  output logic [NIB_W-1:0]      rdSig
);
  rbsStrobe_t strb;

  rbs_ctrl #(
    .NUM_CHAN(NUM_CHAN), .FRAME_W(FRAME_W), .SIG_STEP(SIG_STEP),
    .ESF_LEN(ESF_LEN), .D4_LEN(D4_LEN)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .rxByte(rxByte),
    .frameNum(frameNum), .chanNum(chanNum), .syncOk(syncOk),
    .esfMode(esfMode), .debounceEn(debounceEn), .strb(strb)
  );

  rbs_datapath #(.NUM_CHAN(NUM_CHAN)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .rdChan(rdChan), .rdSig(rdSig)
  );
endmodule

// File: tb/tb_rbs_store.sv
`timescale 1ns/1ps
module tb_rbs_store;
  logic       clk = 1'b0;
  logic       rstN;
  logic       byteValid;
  logic [7:0] rxByte;
  logic [4:0] frameNum;
  logic [4:0] chanNum;
  logic       syncOk;
  logic       esfMode;
  logic       debounceEn;
  logic [4:0] rdChan;
  logic [3:0] rdSig;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [3:0] mStore [24];
  logic [3:0] mCand  [24];
  bit         mClean;
  logic [3:0] expQ [$];
  string      reqQ [$];

  always #2 clk = ~clk;

  rbs_store dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .rxByte(rxByte),
    .frameNum(frameNum), .chanNum(chanNum), .syncOk(syncOk),
    .esfMode(esfMode), .debounceEn(debounceEn), .rdChan(rdChan), .rdSig(rdSig)
  );

  // monitor: compare one expected item per cycle
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      logic [3:0] e;
      string r;
      e = expQ.pop_front();
      r = reqQ.pop_front();
      total++;
      if (rdSig !== e) begin
        bad++;
        $display("FAIL %s rdSig actual=%b expected=%b", r, rdSig, e);
      end
    end
  end

  task automatic pushRead(input logic [4:0] ch, input logic [3:0] e, input string r);
    rdChan = ch;
    expQ.push_back(e);
    reqQ.push_back(r);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byteValid = 1'b0;
    end
  endtask

  task automatic readAll(input string r);
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      byteValid = 1'b0;
      pushRead(5'(c), mStore[c], r);
    end
    idle(3);
  endtask

  task automatic applyModel(input int c, input logic [3:0] p, input bit esf);
    logic [3:0] s;
    s = esf ? p : {p[3:2], 2'b00};
    if (!debounceEn || s == mCand[c]) mStore[c] = s;
    mCand[c] = s;
  endtask

  function automatic logic sigBit(input int f, input logic [3:0] p, input bit esf);
    if (f == 6) return p[3];
    if (f == 12) return p[2];
    if (esf && f == 18) return p[1];
    if (esf && f == 24) return p[0];
    return 1'($urandom);
  endfunction

  // send one multiframe; dropF: frame sent without sync, stopF: last frame sent (0 = full), peek: channel read at commit
  task automatic sendMf(input logic [3:0] p [24], input int dropF, input int stopF, input int peek);
    int len;
    int last;
    bit esf;
    esf  = esfMode;
    len  = esf ? 24 : 12;
    last = (stopF != 0) ? stopF : len;
    for (int f = 1; f <= last; f++) begin
      for (int c = 0; c < 24; c++) begin
        bit sy;
        @(negedge clk);
        sy = (f != dropF);
        byteValid = 1'b1;
        frameNum  = 5'(f);
        chanNum   = 5'(c);
        syncOk    = sy;
        rxByte    = {7'($urandom), sigBit(f, p[c], esf)};
        if (!sy) mClean = 0;
        else if (f == 1 && c == 0) mClean = 1;
        if (f == len && c == peek) pushRead(5'(c), mStore[c], "R5");
        if (sy && f == len && mClean) applyModel(c, p[c], esf);
        if (f == len && peek >= 0 && c == peek + 1) pushRead(5'(peek), mStore[peek], "R5");
      end
    end
    @(negedge clk);
    byteValid = 1'b0;
    syncOk    = 1'b1;
  endtask

  task automatic setMode(input bit esf, input bit deb);
    @(negedge clk);
    byteValid  = 1'b0;
    esfMode    = esf;
    debounceEn = deb;
    mClean     = 0;
    idle(3);
  endtask

  task automatic makePat(output logic [3:0] p [24], input int seed);
    for (int c = 0; c < 24; c++) p[c] = 4'((c * seed + (seed >> 1)) ^ c ^ seed);
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] pa [24];
    logic [3:0] pb [24];
    logic [3:0] pc [24];
    logic [3:0] pd [24];
    logic [3:0] pe [24];
    rstN = 1'b0; byteValid = 1'b0; rxByte = '0; frameNum = '0; chanNum = '0;
    syncOk = 1'b1; esfMode = 1'b1; debounceEn = 1'b0; rdChan = '0; mClean = 0;
    for (int c = 0; c < 24; c++) begin mStore[c] = '0; mCand[c] = '0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    idle(2);

    readAll("R1");                                   // R1 reset state

    makePat(pa, 5); makePat(pb, 11); makePat(pc, 7); makePat(pd, 13); makePat(pe, 3);

    sendMf(pa, 0, 0, 5);                             // R2 capture, R5 same-cycle read
    readAll("R2");
    readAll("R9");                                   // R9 direct replacement

    sendMf(pb, 0, 23, -1);                           // R4 partial multiframe
    readAll("R4");

    sendMf(pb, 12, 0, -1);                           // R6 / R7 sync drop in frame 12
    readAll("R6");
    readAll("R7");
    sendMf(pb, 0, 0, -1);                            // R7 resumes with clean multiframe
    readAll("R7");

    setMode(1'b0, 1'b0);                             // R3 two-bit mode
    sendMf(pc, 0, 0, 3);
    readAll("R3");

    @(negedge clk);                                  // R10 out-of-range channel byte
    byteValid = 1'b1; frameNum = 5'd12; chanNum = 5'd27; rxByte = 8'hFF; syncOk = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
    pushRead(5'd30, 4'b0000, "R10");
    idle(2);
    readAll("R10");

    setMode(1'b1, 1'b1);                             // R8 debounce
    sendMf(pd, 0, 0, -1);
    readAll("R8");
    sendMf(pd, 0, 0, -1);
    readAll("R8");
    sendMf(pe, 0, 0, -1);
    sendMf(pa, 0, 0, -1);
    readAll("R8");
    sendMf(pa, 0, 0, 9);
    readAll("R8");

    idle(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule